// File: doc/BRIEF.md
# PLL Lock Speed-Up Sequencer

This block produces the digital mode requests for the charge pumps of two frequency synthesizer loops. The first is the transmit modulator loop and the second is the receive local-oscillator loop. The goal is fast locking. The block watches the enable of each loop's oscillator and two software speed-up bits. From these it derives three requests:

- a loop-filter precharge request for the modulator loop;
- a high-current request for the modulator charge pump;
- a high-current request for the local-oscillator charge pump.

The analog charge pumps and filters act on these requests.

**Precharge.** While the receiver is active and the modulator oscillator is off, the block asks for the modulator filter to be precharged. The analog side precharges it to roughly half of the regulated charge-pump supply.

**Modulator boost window.** When the modulator oscillator is switched on, the precharge request drops. On the same clock edge, a timed high-current window of 30 ms starts. The window length is computed from the clock-frequency parameter. A software override bit can hold the modulator boost on for any length of time. The override also withholds precharge, so the two requests never overlap. The local-oscillator loop has no timed window; its own software bit drives its high-current request directly.

**State machine.** A state machine with four states sequences the modulator loop:

- `ST_IDLE`: no receive, no modulator.
- `ST_PRECHARGE`: receive mode.
- `ST_BOOST`: the timed window is running.
- `ST_TRACK`: the modulator is on and the window has ended.

Its transitions are:

- **T_RX_ON** (`ST_IDLE` to `ST_PRECHARGE`) and **T_RX_OFF** (back again), following the receive enable while the modulator is off.
- **T_MOD_RISE** (any state to `ST_BOOST`) on a rising edge of the modulator enable.
- **T_EXPIRE** (`ST_BOOST` to `ST_TRACK`) when the timer reaches its terminal count.
- **T_MOD_DROP** (`ST_BOOST` or `ST_TRACK` to `ST_IDLE` or `ST_PRECHARGE`) when the modulator enable falls.

Top module: `pll_speedup_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, all three outputs are 0.
- R2: `precharge_o` is 1 in the cycle after a clock edge that sampled `rx_osc_en_i`=1, `mod_osc_en_i`=0 and `mod_force_i`=0. It is 0 after any other sampled combination.
- R3: After a clock edge that samples a rising edge of `mod_osc_en_i`, `mod_boost_o` stays 1 for exactly TC cycles, where TC = round(0.030 × CLK_HZ), provided the enable stays high. With the bench parameter CLK_HZ = 100000, TC is 3000.
- R4: Every new rising edge of `mod_osc_en_i` restarts a full TC-cycle window, whatever window came before.
- R5: If `mod_osc_en_i` is sampled low while a window is running, the window ends. `mod_boost_o` then follows `mod_force_i` from the next cycle.
- R6: While `mod_force_i` is sampled 1, `mod_boost_o` is 1 in the next cycle and `precharge_o` is 0, in every state.
- R7: `lo_boost_o` equals the value of `lo_force_i` sampled at the previous clock edge, independent of all other inputs.
- R8: On the edge that samples a rising edge of the modulator enable, `precharge_o` falls and `mod_boost_o` rises together. The two outputs are never 1 at the same time.
- R9: Once the window has expired with the modulator enable still high, `mod_boost_o` equals the sampled `mod_force_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mod_osc_en_i | input | 1 | Modulator loop oscillator enable |
| rx_osc_en_i | input | 1 | Receive local-oscillator enable |
| mod_force_i | input | 1 | Software override: modulator high current |
| lo_force_i | input | 1 | Software override: local-oscillator high current |
| precharge_o | output | 1 | Modulator loop-filter precharge request |
| mod_boost_o | output | 1 | Modulator charge-pump high-current request |
| lo_boost_o | output | 1 | Local-oscillator charge-pump high-current request |

## Verification
The assertions check the following on every cycle:

- Precharge and modulator boost are never 1 together.
- Precharge only follows sampled receive mode with no override.
- The local-oscillator request tracks its software bit one cycle later.
- A sampled modulator rising edge always yields boost without precharge.
- A sampled low enable leaves boost equal to the override.

The exact length of the timed window depends on a large parameter. Its restart on a fresh edge and the quiet period after expiry can only be shown by the bench. The bench does this with its behavioural countdown model and its measured window lengths.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PRECHARGE = 2'd1,
        ST_BOOST     = 2'd2,
        ST_TRACK     = 2'd3
    } seq_state_t;

    // round(window_us * clk_hz / 1e6), done in 64-bit to avoid overflow
    function automatic longint unsigned window_cycles(longint unsigned clk_hz,
                                                      longint unsigned win_us);
        return (clk_hz * win_us + 64'd500000) / 64'd1000000;
    endfunction

endpackage

// File: rtl/seq_window_timer.sv
module seq_window_timer #(
    parameter longint unsigned TC = 64'd3750000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic run_i,
    output logic last_o
);
    localparam int CNT_W = (TC < 2) ? 1 : $clog2(TC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TC - 64'd1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign last_o = run_i && (cnt_q == CNT_LAST);

endmodule

// File: rtl/seq_mod_fsm.sv
module seq_mod_fsm
    import pll_seq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       mod_en_i,
    input  logic       rx_en_i,
    input  logic       force_i,
    input  logic       win_last_i,
    output logic       win_start_o,
    output logic       win_run_o,
    output logic       precharge_o,
    output logic       boost_o
);
    seq_state_t state_q, state_nxt;
    logic       mod_en_q;

    assign win_start_o = mod_en_i && !mod_en_q;
    assign win_run_o   = (state_q == ST_BOOST);

    // next-state selection
    always_comb begin
        state_nxt = state_q;
        if (!mod_en_i) begin
            // T_MOD_DROP, T_RX_ON, T_RX_OFF
            state_nxt = rx_en_i ? ST_PRECHARGE : ST_IDLE;
        end else if (win_start_o) begin
            // T_MOD_RISE
            state_nxt = ST_BOOST;
        end else begin
            unique case (state_q)
                ST_BOOST:     state_nxt = win_last_i ? ST_TRACK : ST_BOOST; // T_EXPIRE
                ST_TRACK:     state_nxt = ST_TRACK;
                ST_IDLE:      state_nxt = ST_TRACK;
                ST_PRECHARGE: state_nxt = ST_TRACK;
                default:      state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q  <= ST_IDLE;
            mod_en_q <= 1'b0;
        end else begin
            state_q  <= state_nxt;
            mod_en_q <= mod_en_i;
        end
    end

    // registered outputs decoded from the next state
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            precharge_o <= 1'b0;
            boost_o     <= 1'b0;
        end else begin
            precharge_o <= (state_nxt == ST_PRECHARGE) && !force_i;
            boost_o     <= (state_nxt == ST_BOOST) || force_i;
        end
    end

endmodule

// File: rtl/seq_lo_ctrl.sv
module seq_lo_ctrl (
    input  logic clk_i,
    input  logic rst_i,
    input  logic force_i,
    output logic boost_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) boost_o <= 1'b0;
        else       boost_o <= force_i;
    end
endmodule

// File: rtl/pll_speedup_seq.sv
module pll_speedup_seq
    import pll_seq_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 64'd125000000,
    parameter longint unsigned WINDOW_US = 64'd30000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mod_osc_en_i,
    input  logic rx_osc_en_i,
    input  logic mod_force_i,
    input  logic lo_force_i,
    output logic precharge_o,
    output logic mod_boost_o,
    output logic lo_boost_o
);
    localparam longint unsigned TC_RAW = window_cycles(CLK_HZ, WINDOW_US);
    localparam longint unsigned TC     = (TC_RAW < 2) ? 64'd2 : TC_RAW;

    logic win_start, win_run, win_last;

    seq_mod_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .mod_en_i    (mod_osc_en_i),
        .rx_en_i     (rx_osc_en_i),
        .force_i     (mod_force_i),
        .win_last_i  (win_last),
        .win_start_o (win_start),
        .win_run_o   (win_run),
        .precharge_o (precharge_o),
        .boost_o     (mod_boost_o)
    );

    seq_window_timer #(.TC(TC)) u_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (win_start),
        .run_i   (win_run),
        .last_o  (win_last)
    );

    seq_lo_ctrl u_lo (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .force_i (lo_force_i),
        .boost_o (lo_boost_o)
    );

endmodule

// File: rtl/pll_speedup_seq_chk.sv
module pll_speedup_seq_chk (
    input logic clk_i,
    input logic rst_i,
    input logic mod_osc_en_i,
    input logic rx_osc_en_i,
    input logic mod_force_i,
    input logic lo_force_i,
    input logic precharge_o,
    input logic mod_boost_o,
    input logic lo_boost_o
);
    assert_exclusive_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(precharge_o && mod_boost_o));

    assert_precharge_cause_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && precharge_o) |-> $past(rx_osc_en_i && !mod_osc_en_i && !mod_force_i));

    assert_lo_follow_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) |-> (lo_boost_o == $past(lo_force_i)));

    assert_rise_boost_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && $past(!rst_i, 2) && $past(mod_osc_en_i) && !$past(mod_osc_en_i, 2))
        |-> (mod_boost_o && !precharge_o));

    assert_drop_abort_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && $past(!mod_osc_en_i)) |-> (mod_boost_o == $past(mod_force_i)));

    assert_force_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && $past(mod_force_i)) |-> (mod_boost_o && !precharge_o));
endmodule

bind pll_speedup_seq pll_speedup_seq_chk u_chk (.*);

// File: tb/pll_speedup_seq_tb.sv
module pll_speedup_seq_tb;
    localparam longint unsigned CLK_HZ = 64'd100000;
    localparam int TC_EXP = $rtoi(0.030 * real'(CLK_HZ) + 0.5);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mod_en = 1'b0, rx_en = 1'b0, su_mod = 1'b0, su_lo = 1'b0;
    logic pre, mboost, lboost;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    pll_speedup_seq #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk_i(clk), .rst_i(rst), .mod_osc_en_i(mod_en), .rx_osc_en_i(rx_en),
        .mod_force_i(su_mod), .lo_force_i(su_lo),
        .precharge_o(pre), .mod_boost_o(mboost), .lo_boost_o(lboost)
    );

    // behavioural reference: countdown of remaining window cycles
    int  left = 0;
    bit  prev_mod = 0;
    bit  e_pre = 0, e_mb = 0, e_lb = 0;
    always @(posedge clk) begin
        if (rst) begin
            left = 0; prev_mod = 0; e_pre = 0; e_mb = 0; e_lb = 0;
        end else begin
            if (mod_en && !prev_mod) left = TC_EXP;
            else if (!mod_en)        left = 0;
            e_mb = (left > 0) || su_mod;
            if (left > 0) left = left - 1;
            e_pre = rx_en && !mod_en && !su_mod;
            e_lb  = su_lo;
            prev_mod = mod_en;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) if (!done) begin
        check(pre == e_pre,   cur_req, "precharge_o", pre, e_pre);
        check(mboost == e_mb, cur_req, "mod_boost_o", mboost, e_mb);
        check(lboost == e_lb, cur_req, "lo_boost_o", lboost, e_lb);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count high cycles of mod_boost_o from now
    task automatic measure(input string req);
        int n = 0;
        while (mboost && n < TC_EXP + 50) begin
            n++;
            @(negedge clk);
        end
        check(n == TC_EXP, req, "window length", n, TC_EXP);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        su_lo = 1'b1; su_mod = 1'b1; rx_en = 1'b1;
        cyc(5);
        check(!pre && !mboost && !lboost, "R1", "outputs in reset", {pre, mboost, lboost}, 0);
        su_lo = 1'b0; su_mod = 1'b0; rx_en = 1'b0;
        rst = 1'b0;
        cyc(1);
        check(!pre && !mboost && !lboost, "R1", "outputs after reset", {pre, mboost, lboost}, 0);

        // R2 receive-mode precharge
        cur_req = "R2";
        rx_en = 1'b1;
        cyc(1);
        check(pre == 1'b1, "R2", "precharge in rx mode", pre, 1);
        cyc(20);
        rx_en = 1'b0;
        cyc(1);
        check(pre == 1'b0, "R2", "precharge after rx off", pre, 0);

        // R8 and R3: rise from precharge, full window
        cur_req = "R8";
        rx_en = 1'b1; cyc(10);
        mod_en = 1'b1;
        cyc(1);
        check(!pre && mboost, "R8", "handover on rise", {pre, mboost}, 1);
        cur_req = "R3";
        measure("R3");
        // R9: after expiry with enable still high
        cur_req = "R9";
        cyc(20);
        check(mboost == 1'b0, "R9", "boost after expiry", mboost, 0);
        su_mod = 1'b1; cyc(1);
        check(mboost == 1'b1, "R9", "override after expiry", mboost, 1);
        su_mod = 1'b0; cyc(5);

        // R5: drop mid-window
        cur_req = "R5";
        mod_en = 1'b0; rx_en = 1'b0; cyc(5);
        mod_en = 1'b1; cyc(100);
        mod_en = 1'b0; cyc(1);
        check(mboost == 1'b0, "R5", "abort on drop", mboost, 0);
        cyc(10);

        // R4: restart after short gap late in a window
        cur_req = "R4";
        mod_en = 1'b1; cyc(TC_EXP - 10);
        mod_en = 1'b0; cyc(1);
        mod_en = 1'b1; cyc(1);
        measure("R4");
        mod_en = 1'b0; cyc(5);

        // R6: override in receive mode and in idle
        cur_req = "R6";
        rx_en = 1'b1; su_mod = 1'b1; cyc(1);
        check(mboost && !pre, "R6", "override beats precharge", {pre, mboost}, 1);
        cyc(30);
        rx_en = 1'b0; cyc(5);
        check(mboost == 1'b1, "R6", "override in idle", mboost, 1);
        su_mod = 1'b0; cyc(1);
        check(mboost == 1'b0, "R6", "override released", mboost, 0);

        // R7: local-oscillator override alone and mixed
        cur_req = "R7";
        su_lo = 1'b1; cyc(1);
        check(lboost == 1'b1, "R7", "lo boost set", lboost, 1);
        mod_en = 1'b1; rx_en = 1'b1; cyc(50);
        check(lboost == 1'b1, "R7", "lo boost held", lboost, 1);
        su_lo = 1'b0; cyc(1);
        check(lboost == 1'b0, "R7", "lo boost cleared", lboost, 0);
        for (int i = 0; i < 40; i++) begin
            su_lo = i[0]; su_mod = i[2]; mod_en = (i % 7) != 0; rx_en = i[1];
            cyc(1);
        end
        su_lo = 1'b0; su_mod = 1'b0; mod_en = 1'b0; rx_en = 1'b0;
        cyc(5);
        finish_run();
    end
endmodule